// File: doc/BRIEF.md
# Shared Counter and Per-Target Compare Timer

This block holds one free-running counter shared by several processor targets and, for each target, a compare value that raises that target's timer interrupt. The counter width is fixed at build time as 32 plus four times an extension count. The counter starts out halted and is read and written as two 32-bit halves through a simple word-addressed register port. A read is combinational: its data is valid in the same cycle the request is held.

Each target owns a small set of local registers. These are the compare halves, a pending view, an enable mask with separate set and clear ports, a software-interrupt control word, one routing word per local source and a redirect selector. Accesses can reach these registers in two ways. The local window always targets the requester itself. The other window targets whichever target the requester last named in its redirect selector, so one target can program another target's compare. Every local source is routed to one of the target's output pins when the source is pending, enabled and its routing word is valid.

Top module: `gcnt_cmp_unit`

## Requirements
- R1: After reset the counter reads 0, the stop bit is set, every compare half reads 0xFFFFFFFF, mask, pending and software control read 0, and all pins are low.
- R2: While the stop bit (config bit 0) is set the counter holds its value. While the stop bit is clear the counter advances by exactly one per clock, starting with the edge after the write that clears the bit.
- R3: The counter reads as a low half (shared offset 1) and a high half (shared offset 2). A carry out of the low half is visible in the next read of the high half, so a high-low-high read that straddles the carry shows two different high values.
- R4: Writes to either counter half load that half only while the counter is stopped. While the counter runs, such writes are ignored.
- R5: A target's timer pending bit sets when the counter equals that target's full-width compare value. It stays set until either compare half (local offsets 0 = low, 1 = high) is written.
- R6: Local offset 4 sets, and offset 5 clears, mask bits wherever the written bit is one. Offset 3 reads the mask. The bit order is bit 0 = timer, bit 1 = software 0, bit 2 = software 1.
- R7: Bits [1:0] of the software control word (local offset 6) are the pending state of software sources 0 and 1. Offset 2 reads the pending word in the bit order of R6.
- R8: A value written to local offset 7 selects the target that the other window (address bits [7:6] = 11) reaches. The local window (bits [7:6] = 10) always reaches the requester. Offset 7 is neither written nor read through the other window.
- R9: Routing words sit at local offsets 8, 9 and 10 for timer, software 0 and software 1. Bit 31 is the valid bit and bits [4:0] are the pin number. Pin p of target t (irq_pin bit t*NUM_PINS+p) is high exactly when some source routed validly to p is both pending and enabled.
- R10: The config word (shared offset 0) reads the stop bit at bit 0 and the read-only extension count at bits [11:8]. Writes leave the extension count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_target | input | $clog2(NUM_TARGETS) | Index of the requesting target |
| req_addr | input | 8 | Word address: [7:6] region, low bits offset |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, valid while a read request is held |
| irq_pin | output | NUM_TARGETS*NUM_PINS | Interrupt pins, NUM_PINS per target |

## Verification
The hardest case to reach from the ports is a carry out of the low counter half landing between two reads of the high half, because it would normally take billions of cycles. The bench stops the counter, loads it two counts below the carry, restarts it and then issues back-to-back reads. It computes the exact value each read sees, so it expects a mismatched high-low-high triple followed by a consistent retry. Compare matches are reached the same way, by preloading the counter just below a chosen compare value.

// File: rtl/gcnt_pkg.sv
package gcnt_pkg;

    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 8;
    localparam int NSRC    = 3;
    localparam int PIN_F_W = 5;

    // address regions, decoded from addr[7:6]
    typedef enum logic [1:0] {
        RGN_SHARED = 2'b00,
        RGN_RSVD   = 2'b01,
        RGN_LOCAL  = 2'b10,
        RGN_OTHER  = 2'b11
    } region_e;

    // shared offsets (addr[5:0])
    localparam logic [5:0] SH_CFG    = 6'd0;
    localparam logic [5:0] SH_CNT_LO = 6'd1;
    localparam logic [5:0] SH_CNT_HI = 6'd2;

    // local offsets (addr[3:0])
    localparam logic [3:0] LO_CMP_LO  = 4'd0;
    localparam logic [3:0] LO_CMP_HI  = 4'd1;
    localparam logic [3:0] LO_PEND    = 4'd2;
    localparam logic [3:0] LO_MASK    = 4'd3;
    localparam logic [3:0] LO_MSET    = 4'd4;
    localparam logic [3:0] LO_MCLR    = 4'd5;
    localparam logic [3:0] LO_SWCTL   = 4'd6;
    localparam logic [3:0] LO_REDIR   = 4'd7;
    localparam logic [3:0] LO_MAP_TMR = 4'd8;
    localparam logic [3:0] LO_MAP_SW0 = 4'd9;
    localparam logic [3:0] LO_MAP_SW1 = 4'd10;

    // local source positions
    localparam int SRC_TMR = 0;
    localparam int SRC_SW0 = 1;
    localparam int SRC_SW1 = 2;

    typedef struct packed {
        logic               valid;
        logic [PIN_F_W-1:0] pin;
    } route_t;

    typedef struct packed {
        logic              wr;
        logic [3:0]        off;
        logic [DATA_W-1:0] wdata;
    } lreq_t;

    function automatic logic [63:0] count_mask(input int ext);
        int w;
        w = 32 + 4 * ext;
        if (w >= 64) return '1;
        return (64'd1 << w) - 64'd1;
    endfunction

    function automatic logic [DATA_W-1:0] route_word(input route_t r);
        return {r.valid, {(DATA_W-1-PIN_F_W){1'b0}}, r.pin};
    endfunction

endpackage

// File: rtl/gcnt_counter.sv
module gcnt_counter
    import gcnt_pkg::*;
#(
    parameter int COUNT_EXT = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic              lo_wr,
    input  logic              hi_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [63:0]       cnt,
    output logic              stop,
    output logic              load
);
    localparam logic [63:0] MASK = count_mask(COUNT_EXT);

    logic [63:0] cnt_q;
    logic        stop_q;

    assign load = (lo_wr || hi_wr) && stop_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            stop_q <= 1'b1;
        end else begin
            if (cfg_wr) stop_q <= wdata[0];
            if (lo_wr && stop_q)
                cnt_q <= {cnt_q[63:32], wdata} & MASK;
            else if (hi_wr && stop_q)
                cnt_q <= {wdata, cnt_q[31:0]} & MASK;
            else if (!stop_q)
                cnt_q <= (cnt_q + 64'd1) & MASK;
        end
    end

    assign cnt  = cnt_q;
    assign stop = stop_q;
endmodule

// File: rtl/gcnt_target.sv
module gcnt_target
    import gcnt_pkg::*;
#(
    parameter int COUNT_EXT = 8,
    parameter int NUM_PINS  = 6,
    parameter int TIDW      = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [63:0]       cnt,
    input  logic              en,
    input  logic              via_other,
    input  lreq_t             req,
    output logic [DATA_W-1:0] rdata,
    output logic [TIDW-1:0]   redir,
    output logic [NUM_PINS-1:0] pins,
    output logic              cmp_wr,
    output logic              tmr_pend,
    output logic [NSRC-1:0]   act
);
    localparam logic [63:0] MASK = count_mask(COUNT_EXT);

    logic [63:0]     cmp_q;
    logic            tpend_q;
    logic [NSRC-1:0] mask_q;
    logic [1:0]      sw_q;
    logic [TIDW-1:0] redir_q;
    route_t          route_q [NSRC];

    logic            wr;
    logic            hit;
    logic [NSRC-1:0] pend;

    assign wr     = en && req.wr;
    assign cmp_wr = wr && (req.off == LO_CMP_LO || req.off == LO_CMP_HI);
    assign hit    = (cnt & MASK) == (cmp_q & MASK);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q   <= '1;
            tpend_q <= 1'b0;
            mask_q  <= '0;
            sw_q    <= '0;
            redir_q <= '0;
            for (int s = 0; s < NSRC; s++) route_q[s] <= '0;
        end else begin
            if (cmp_wr)   tpend_q <= 1'b0;
            else if (hit) tpend_q <= 1'b1;
            if (wr) begin
                case (req.off)
                    LO_CMP_LO:  cmp_q[31:0]  <= req.wdata;
                    LO_CMP_HI:  cmp_q[63:32] <= req.wdata;
                    LO_MSET:    mask_q <= mask_q | req.wdata[NSRC-1:0];
                    LO_MCLR:    mask_q <= mask_q & ~req.wdata[NSRC-1:0];
                    LO_SWCTL:   sw_q   <= req.wdata[1:0];
                    LO_REDIR:   if (!via_other) redir_q <= req.wdata[TIDW-1:0];
                    LO_MAP_TMR: route_q[SRC_TMR] <= '{req.wdata[31], req.wdata[PIN_F_W-1:0]};
                    LO_MAP_SW0: route_q[SRC_SW0] <= '{req.wdata[31], req.wdata[PIN_F_W-1:0]};
                    LO_MAP_SW1: route_q[SRC_SW1] <= '{req.wdata[31], req.wdata[PIN_F_W-1:0]};
                    default: ;
                endcase
            end
        end
    end

    assign pend     = {sw_q[1], sw_q[0], tpend_q};
    assign act      = pend & mask_q;
    assign tmr_pend = tpend_q;
    assign redir    = redir_q;

    // pin routing: one OR tree per output pin
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        always_comb begin
            pins[p] = 1'b0;
            for (int s = 0; s < NSRC; s++)
                if (act[s] && route_q[s].valid &&
                    route_q[s].pin == PIN_F_W'(p))
                    pins[p] = 1'b1;
        end
    end

    always_comb begin
        rdata = '0;
        case (req.off)
            LO_CMP_LO:  rdata = cmp_q[31:0];
            LO_CMP_HI:  rdata = cmp_q[63:32];
            LO_PEND:    rdata = DATA_W'(pend);
            LO_MASK:    rdata = DATA_W'(mask_q);
            LO_SWCTL:   rdata = DATA_W'(sw_q);
            LO_REDIR:   rdata = via_other ? '0 : DATA_W'(redir_q);
            LO_MAP_TMR: rdata = route_word(route_q[SRC_TMR]);
            LO_MAP_SW0: rdata = route_word(route_q[SRC_SW0]);
            LO_MAP_SW1: rdata = route_word(route_q[SRC_SW1]);
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/gcnt_cmp_unit.sv
module gcnt_cmp_unit
    import gcnt_pkg::*;
#(
    parameter int NUM_TARGETS = 4,
    parameter int COUNT_EXT   = 8,
    parameter int NUM_PINS    = 6
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           req_valid,
    input  logic                           req_write,
    input  logic [$clog2(NUM_TARGETS)-1:0] req_target,
    input  logic [ADDR_W-1:0]              req_addr,
    input  logic [DATA_W-1:0]              req_wdata,
    output logic [DATA_W-1:0]              rsp_rdata,
    output logic [NUM_TARGETS*NUM_PINS-1:0] irq_pin
);
    localparam int TIDW = $clog2(NUM_TARGETS);

    region_e   region;
    logic [5:0] sh_off;
    logic       sh_wr;
    logic [63:0] cnt_q;
    logic        stop_q;
    logic        cnt_load;

    logic [TIDW-1:0]   redir   [NUM_TARGETS];
    logic [DATA_W-1:0] trd     [NUM_TARGETS];
    logic [TIDW-1:0]   eff_tgt;
    logic              in_win;
    lreq_t             lreq;

    logic [NUM_TARGETS-1:0]      cmp_wr_vec;
    logic [NUM_TARGETS-1:0]      tmr_pend_vec;
    logic [NUM_TARGETS*NSRC-1:0] act_vec;

    assign region = region_e'(req_addr[7:6]);
    assign sh_off = req_addr[5:0];
    assign sh_wr  = req_valid && req_write && region == RGN_SHARED;

    gcnt_counter #(.COUNT_EXT(COUNT_EXT)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .cfg_wr (sh_wr && sh_off == SH_CFG),
        .lo_wr  (sh_wr && sh_off == SH_CNT_LO),
        .hi_wr  (sh_wr && sh_off == SH_CNT_HI),
        .wdata  (req_wdata),
        .cnt    (cnt_q),
        .stop   (stop_q),
        .load   (cnt_load)
    );

    assign in_win  = region == RGN_LOCAL || region == RGN_OTHER;
    assign eff_tgt = (region == RGN_OTHER) ? redir[req_target] : req_target;
    assign lreq    = '{wr: req_write, off: req_addr[3:0], wdata: req_wdata};

    for (genvar i = 0; i < NUM_TARGETS; i++) begin : g_tgt
        gcnt_target #(
            .COUNT_EXT (COUNT_EXT),
            .NUM_PINS  (NUM_PINS),
            .TIDW      (TIDW)
        ) u_tgt (
            .clk       (clk),
            .rst       (rst),
            .cnt       (cnt_q),
            .en        (req_valid && in_win && eff_tgt == TIDW'(i)),
            .via_other (region == RGN_OTHER),
            .req       (lreq),
            .rdata     (trd[i]),
            .redir     (redir[i]),
            .pins      (irq_pin[i*NUM_PINS +: NUM_PINS]),
            .cmp_wr    (cmp_wr_vec[i]),
            .tmr_pend  (tmr_pend_vec[i]),
            .act       (act_vec[i*NSRC +: NSRC])
        );
    end

    always_comb begin
        rsp_rdata = '0;
        if (req_valid && !req_write) begin
            case (region)
                RGN_SHARED: begin
                    case (sh_off)
                        SH_CFG:    rsp_rdata = {20'd0, 4'(COUNT_EXT), 7'd0, stop_q};
                        SH_CNT_LO: rsp_rdata = cnt_q[31:0];
                        SH_CNT_HI: rsp_rdata = cnt_q[63:32];
                        default:   rsp_rdata = '0;
                    endcase
                end
                RGN_LOCAL, RGN_OTHER: rsp_rdata = trd[eff_tgt];
                default: rsp_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/gcnt_cmp_unit_chk.sv
module gcnt_cmp_unit_chk #(
    parameter int NT        = 4,
    parameter int NPINS     = 6,
    parameter int COUNT_EXT = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic [63:0]          cnt,
    input logic                 stop,
    input logic                 load,
    input logic [NT-1:0]        cmp_wr,
    input logic [NT-1:0]        tmr_pend,
    input logic [NT*3-1:0]      act,
    input logic [NT*NPINS-1:0]  irq_pin
);
    localparam logic [63:0] MASK = gcnt_pkg::count_mask(COUNT_EXT);

    assert_stop_holds_R2: assert property (@(posedge clk) disable iff (rst)
        ($past(stop) && !$past(load)) |-> $stable(cnt));

    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(stop) |-> cnt == (($past(cnt) + 64'd1) & MASK));

    for (genvar t = 0; t < NT; t++) begin : g_t
        assert_pend_clear_R5: assert property (@(posedge clk) disable iff (rst)
            $past(cmp_wr[t]) |-> !tmr_pend[t]);

        assert_pend_hold_R5: assert property (@(posedge clk) disable iff (rst)
            ($past(tmr_pend[t]) && !$past(cmp_wr[t])) |-> tmr_pend[t]);

        assert_pin_cause_R9: assert property (@(posedge clk) disable iff (rst)
            (|irq_pin[t*NPINS +: NPINS]) |-> (|act[t*3 +: 3]));
    end
endmodule

bind gcnt_cmp_unit gcnt_cmp_unit_chk #(
    .NT        (NUM_TARGETS),
    .NPINS     (NUM_PINS),
    .COUNT_EXT (COUNT_EXT)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cnt      (cnt_q),
    .stop     (stop_q),
    .load     (cnt_load),
    .cmp_wr   (cmp_wr_vec),
    .tmr_pend (tmr_pend_vec),
    .act      (act_vec),
    .irq_pin  (irq_pin)
);

// File: tb/gcnt_cmp_unit_tb.sv
`timescale 1ns/1ps
module gcnt_cmp_unit_tb;
    localparam int NT = 4;
    localparam int NP = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_target = '0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_rdata;
    logic [NT*NP-1:0] irq_pin;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    gcnt_cmp_unit #(.NUM_TARGETS(NT), .COUNT_EXT(8), .NUM_PINS(NP)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_target(req_target), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .irq_pin(irq_pin)
    );

    function automatic logic [7:0] sh(input int off);  return 8'(off);        endfunction
    function automatic logic [7:0] loc(input int off); return 8'h80 | 8'(off); endfunction
    function automatic logic [7:0] oth(input int off); return 8'hC0 | 8'(off); endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int tgt, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1;
        req_target = 2'(tgt); req_addr = a; req_wdata = d;
        @(posedge clk);
        #1 req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input int tgt, input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0;
        req_target = 2'(tgt); req_addr = a;
        #2 d = rsp_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(0, sh(0), d); chk("R1 R10 cfg after reset", 64'(d), 64'h801);
        rd(0, sh(1), d); chk("R1 count lo", 64'(d), 0);
        rd(0, sh(2), d); chk("R1 count hi", 64'(d), 0);
        rd(1, loc(0), d); chk("R1 compare lo", 64'(d), 64'hFFFF_FFFF);
        rd(1, loc(1), d); chk("R1 compare hi", 64'(d), 64'hFFFF_FFFF);
        rd(0, loc(2), d); chk("R1 pending", 64'(d), 0);
        rd(0, loc(3), d); chk("R1 mask", 64'(d), 0);
        chk("R1 pins", 64'(irq_pin), 0);
    endtask

    task automatic t_stop;
        logic [31:0] a, b, c;
        rd(0, sh(1), a); rd(0, sh(1), b);
        chk("R2 held while stopped", 64'(b), 64'(a));
        wr(0, sh(0), 32'h0);
        rd(0, sh(1), a); rd(0, sh(1), b); rd(0, sh(1), c);
        chk("R2 first read after start", 64'(a), 0);
        chk("R2 step one", 64'(b), 1);
        chk("R2 step two", 64'(c), 2);
        wr(0, sh(0), 32'hF01);
        rd(0, sh(1), a); rd(0, sh(1), b);
        chk("R2 frozen after stop", 64'(b), 64'(a));
        rd(0, sh(0), c); chk("R10 ext field read-only", 64'(c), 64'h801);
    endtask

    task automatic t_carry;
        logic [31:0] h1, l, h2;
        wr(0, sh(2), 32'h0);
        wr(0, sh(1), 32'hFFFF_FFFE);
        rd(0, sh(1), l); chk("R4 load lo while stopped", 64'(l), 64'hFFFF_FFFE);
        wr(0, sh(0), 32'h0);
        rd(0, sh(2), h1); rd(0, sh(1), l); rd(0, sh(2), h2);
        chk("R3 first hi", 64'(h1), 0);
        chk("R3 lo before carry", 64'(l), 64'hFFFF_FFFF);
        chk("R3 carry seen in second hi", 64'(h2), 1);
        rd(0, sh(2), h1); rd(0, sh(1), l); rd(0, sh(2), h2);
        chk("R3 retry consistent", 64'(h1 == h2), 1);
        chk("R3 retry value", {h1, l}, 64'h1_0000_0002);
        wr(0, sh(2), 32'hABCD);
        wr(0, sh(0), 32'h1);
        rd(0, sh(2), h1); chk("R4 hi write ignored while running", 64'(h1), 1);
    endtask

    task automatic t_compare;
        logic [31:0] d;
        wr(0, sh(2), 32'h0);
        wr(0, sh(1), 32'd100);
        wr(0, loc(1), 32'h0);
        wr(0, loc(0), 32'd105);
        rd(0, loc(2), d); chk("R5 not pending before match", 64'(d), 0);
        wr(0, sh(0), 32'h0);
        repeat (12) @(posedge clk);
        wr(0, sh(0), 32'h1);
        rd(0, loc(2), d); chk("R5 pending after match", 64'(d), 1);
        rd(1, loc(2), d); chk("R5 other target unaffected", 64'(d), 0);
        repeat (3) @(posedge clk);
        rd(0, loc(2), d); chk("R5 pending holds", 64'(d), 1);
        wr(0, loc(1), 32'h0);
        rd(0, loc(2), d); chk("R5 cleared by compare hi write", 64'(d), 0);
    endtask

    task automatic t_mask;
        logic [31:0] d;
        wr(0, loc(4), 32'h5);
        rd(0, loc(3), d); chk("R6 set bits", 64'(d), 5);
        wr(0, loc(5), 32'h1);
        rd(0, loc(3), d); chk("R6 clear one bit", 64'(d), 4);
        wr(0, loc(5), 32'h4);
        rd(0, loc(3), d); chk("R6 clear last bit", 64'(d), 0);
    endtask

    task automatic t_sw_pins;
        logic [31:0] d;
        wr(1, loc(6), 32'h1);
        rd(1, loc(2), d); chk("R7 sw0 pending", 64'(d), 2);
        chk("R9 masked source gives no pin", 64'(irq_pin), 0);
        wr(1, loc(4), 32'h2);
        chk("R9 invalid route gives no pin", 64'(irq_pin), 0);
        wr(1, loc(9), 32'h8000_0003);
        chk("R9 routed pin", 64'(irq_pin), 64'(1) << (NP + 3));
        rd(1, loc(9), d); chk("R9 route readback", 64'(d), 64'h8000_0003);
        wr(1, loc(6), 32'h0);
        chk("R7 sw0 cleared drops pin", 64'(irq_pin), 0);
    endtask

    task automatic t_other;
        logic [31:0] d;
        wr(0, loc(7), 32'h2);
        wr(0, oth(0), 32'h1234);
        rd(2, loc(0), d); chk("R8 other window reaches target 2", 64'(d), 64'h1234);
        rd(0, loc(0), d); chk("R8 own compare untouched", 64'(d), 105);
        rd(0, oth(0), d); chk("R8 read through other window", 64'(d), 64'h1234);
        wr(0, oth(4), 32'h1);
        rd(2, loc(3), d); chk("R8 mask set through other window", 64'(d), 1);
        wr(0, oth(7), 32'h3);
        rd(0, loc(7), d); chk("R8 redirect not writable via other", 64'(d), 2);
        rd(2, loc(7), d); chk("R8 target 2 redirect untouched", 64'(d), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_stop();
        t_carry();
        t_compare();
        t_mask();
        t_sw_pins();
        t_other();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule